// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block passes an eight-bit word between two buses, called the A side and the B side, in either direction. Each direction owns a snapshot register that takes a copy of its source bus when that direction's capture strobe rises. Each output side then forwards one of two sources, chosen by its own select. One source is the live word now on the opposite bus. The other is the snapshot held for that direction. Data is never inverted.

The whole block runs on one system clock. The capture strobes are sampled on that clock, and a capture happens on the cycle in which a strobe is seen high after being seen low. Every output is registered, so a change of select or source shows up cleanly on the next clock edge and never as a transient mixture. The three-state drive of each bus is exported as a data word plus an output-enable bit, which the pad ring turns into real three-state buffers. A low enable means the pad is high-impedance.

The A-to-B enable is active-high and the B-to-A enable is active-low. Both directions may therefore drive at the same time. That is a valid exchange only when both sides forward their stored snapshots. If either side forwards live data while both sides drive, the buses are in contention and no valid transfer takes place.

Top module: `xcvr_reg8`

## Requirements
- R1: While `rst` is high at a clock edge, both snapshot registers clear to zero, both enables `a_oe` and `b_oe` go to 0, and both data outputs go to zero after that edge.
- R2: The A-side snapshot loads `a_i` at a clock edge where `cap_a_clk` is 1 and was 0 at the previous edge. It holds at every other edge, including while `cap_a_clk` stays high.
- R3: The B-side snapshot loads `b_i` under the same rising-strobe rule, using `cap_b_clk`.
- R4: After each clock edge, `b_oe` equals the value `en_ab` had at that edge (1 = drive B).
- R5: After each clock edge, `a_oe` equals the inverse of the value `en_ba_n` had at that edge (0 on `en_ba_n` = drive A).
- R6: When a side's enable output is 0, that side's data output is all zeros.
- R7: With `en_ab`=1 and `pick_ab`=0 (live) at an edge, `b_o` after that edge equals `a_i` sampled at that edge, bit for bit and uninverted.
- R8: With `en_ab`=1 and `pick_ab`=1 (stored) at an edge, `b_o` equals the A snapshot as it stood before that edge. A capture made at the same edge becomes visible one cycle later.
- R9: With `en_ba_n`=0 and `pick_ba`=0 (live) at an edge, `a_o` after that edge equals `b_i` sampled at that edge.
- R10: With `en_ba_n`=0 and `pick_ba`=1 (stored) at an edge, `a_o` equals the B snapshot as it stood before that edge.
- R11: When a select changes, the output moves from the old source to the new source in exactly one clock edge. No cycle ever shows any value other than the one the select chose at the previous edge.
- R12: With both directions enabled and both selects on stored, `a_o` and `b_o` carry the two snapshots crossed over in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 8 | Word read from the A bus |
| b_i | input | 8 | Word read from the B bus |
| cap_a_clk | input | 1 | Capture strobe for the A-side snapshot (rising) |
| cap_b_clk | input | 1 | Capture strobe for the B-side snapshot (rising) |
| pick_ab | input | 1 | B-side source: 0 live A, 1 stored A |
| pick_ba | input | 1 | A-side source: 0 live B, 1 stored B |
| en_ab | input | 1 | Drive the B bus, active high |
| en_ba_n | input | 1 | Drive the A bus, active low |
| a_o | output | 8 | Word to drive onto the A bus |
| a_oe | output | 1 | A-bus pad enable (0 = high-impedance) |
| b_o | output | 8 | Word to drive onto the B bus |
| b_oe | output | 1 | B-bus pad enable (0 = high-impedance) |

## Verification
The bench holds a capture strobe high across several cycles while the source word changes. A design that captured on level would then show a later word instead of the first one. It raises a strobe in the same cycle that the select moves to stored, which exposes a design that lets a fresh capture through one cycle early. It toggles the selects back and forth and drives both directions in a stored-to-stored exchange. A design with a wrong enable polarity, or with crossed paths, would drive the wrong side or swap the words. Cycles where both sides drive and either side is live are counted as contention, and their data is left uncompared.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DATA_W = 8;
  localparam int N_DIR  = 2;
  typedef enum logic {SRC_LIVE = 1'b0, SRC_STORED = 1'b1} src_e;
endpackage

// File: rtl/xcvr_snap_reg.sv
module xcvr_snap_reg #(
  parameter int W = xcvr_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic take;

  assign take = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (take) q <= din;
    end
  end
endmodule

// File: rtl/xcvr_out_stage.sv
module xcvr_out_stage #(
  parameter int W = xcvr_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic         doe
);
  import xcvr_pkg::*;
  src_e         src;
  logic [W-1:0] chosen;

  assign src    = src_e'(sel);
  assign chosen = (src == SRC_STORED) ? stored : live;

  always_ff @(posedge clk) begin
    if (rst) begin
      doe  <= 1'b0;
      dout <= '0;
    end else begin
      doe  <= en;
      dout <= en ? chosen : '0;
    end
  end
endmodule

// File: rtl/xcvr_reg8.sv
module xcvr_reg8 #(
  parameter int W = xcvr_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cap_a_clk,
  input  logic         cap_b_clk,
  input  logic         pick_ab,
  input  logic         pick_ba,
  input  logic         en_ab,
  input  logic         en_ba_n,
  output logic [W-1:0] a_o,
  output logic         a_oe,
  output logic [W-1:0] b_o,
  output logic         b_oe
);
  localparam int ND = xcvr_pkg::N_DIR;

  // index 0: A toward B, index 1: B toward A
  logic [W-1:0] src_bus [ND];
  logic         strobe  [ND];
  logic         sel     [ND];
  logic         en      [ND];
  logic [W-1:0] snap    [ND];
  logic [W-1:0] dout    [ND];
  logic         doe     [ND];

  assign src_bus[0] = a_i;
  assign src_bus[1] = b_i;
  assign strobe[0]  = cap_a_clk;
  assign strobe[1]  = cap_b_clk;
  assign sel[0]     = pick_ab;
  assign sel[1]     = pick_ba;
  assign en[0]      = en_ab;
  assign en[1]      = ~en_ba_n;

  for (genvar d = 0; d < ND; d++) begin : g_dir
    xcvr_snap_reg #(.W(W)) snap_i (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe[d]),
      .din    (src_bus[d]),
      .q      (snap[d])
    );
    xcvr_out_stage #(.W(W)) out_i (
      .clk    (clk),
      .rst    (rst),
      .en     (en[d]),
      .sel    (sel[d]),
      .live   (src_bus[d]),
      .stored (snap[d]),
      .dout   (dout[d]),
      .doe    (doe[d])
    );
  end

  assign b_o  = dout[0];
  assign b_oe = doe[0];
  assign a_o  = dout[1];
  assign a_oe = doe[1];
endmodule

// File: rtl/xcvr_reg8_chk.sv
module xcvr_reg8_chk #(
  parameter int W = xcvr_pkg::DATA_W
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         pick_ab,
  input logic         pick_ba,
  input logic         en_ab,
  input logic         en_ba_n,
  input logic [W-1:0] a_o,
  input logic         a_oe,
  input logic [W-1:0] b_o,
  input logic         b_oe
);
  assert_boe_follows_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (b_oe == $past(en_ab)));

  assert_aoe_follows_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_oe == !$past(en_ba_n)));

  assert_b_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !b_oe |-> (b_o == '0));

  assert_a_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !a_oe |-> (a_o == '0));

  assert_b_live_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en_ab) && !$past(pick_ab)) |-> (b_o == $past(a_i)));

  assert_a_live_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_ba_n) && !$past(pick_ba)) |-> (a_o == $past(b_i)));
endmodule

bind xcvr_reg8 xcvr_reg8_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i),
  .pick_ab(pick_ab), .pick_ba(pick_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
  .a_o(a_o), .a_oe(a_oe), .b_o(b_o), .b_oe(b_oe)
);

// File: tb/xcvr_reg8_tb_top.sv
module xcvr_reg8_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic cap_a_clk = 1'b0, cap_b_clk = 1'b0;
  logic pick_ab = 1'b0, pick_ba = 1'b0;
  logic en_ab = 1'b0, en_ba_n = 1'b1;
  logic [W-1:0] a_o, b_o;
  logic a_oe, b_oe;

  always #5 clk = ~clk;

  xcvr_reg8 #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i),
    .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk),
    .pick_ab(pick_ab), .pick_ba(pick_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .a_o(a_o), .a_oe(a_oe), .b_o(b_o), .b_oe(b_oe)
  );

  int checks = 0, errors = 0, contention = 0;
  bit done = 0;

  // behavioural reference state
  logic [W-1:0] m_sa = '0, m_sb = '0;
  logic m_pa = 0, m_pb = 0;
  logic [W-1:0] e_bo = '0, e_ao = '0;
  logic e_boe = 0, e_aoe = 0;
  logic last_pab = 0, last_pba = 0;
  bit chg_ab = 0, chg_ba = 0, st_ab = 0, st_ba = 0, clash = 0, in_rst = 1;
  bit started = 0;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_sa = '0; m_sb = '0; m_pa = 0; m_pb = 0;
      e_bo = '0; e_ao = '0; e_boe = 0; e_aoe = 0;
      in_rst = 1; clash = 0; chg_ab = 0; chg_ba = 0;
    end else begin
      in_rst = 0;
      e_boe = en_ab;
      e_aoe = !en_ba_n;
      e_bo  = en_ab    ? (pick_ab ? m_sa : a_i) : '0;
      e_ao  = !en_ba_n ? (pick_ba ? m_sb : b_i) : '0;
      st_ab = pick_ab; st_ba = pick_ba;
      chg_ab = (pick_ab != last_pab);
      chg_ba = (pick_ba != last_pba);
      clash = e_boe && e_aoe && (!pick_ab || !pick_ba);
      if (cap_a_clk && !m_pa) m_sa = a_i;
      if (cap_b_clk && !m_pb) m_sb = b_i;
      m_pa = cap_a_clk; m_pb = cap_b_clk;
    end
    last_pab = pick_ab; last_pba = pick_ba;
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (in_rst) begin
        chk("R1 b_oe", {7'd0, b_oe}, 8'd0);
        chk("R1 a_oe", {7'd0, a_oe}, 8'd0);
        chk("R1 b_o", b_o, '0);
        chk("R1 a_o", a_o, '0);
      end else begin
        chk("R4 b_oe", {7'd0, b_oe}, {7'd0, e_boe});
        chk("R5 a_oe", {7'd0, a_oe}, {7'd0, e_aoe});
        if (clash) contention++;
        else begin
          if (!e_boe) chk("R6 b_o", b_o, '0);
          else if (chg_ab) chk("R11 b_o", b_o, e_bo);
          else if (e_aoe && st_ab && st_ba) chk("R12 b_o", b_o, e_bo);
          else if (st_ab) chk("R8/R2 b_o", b_o, e_bo);
          else chk("R7 b_o", b_o, e_bo);
          if (!e_aoe) chk("R6 a_o", a_o, '0);
          else if (chg_ba) chk("R11 a_o", a_o, e_ao);
          else if (e_boe && st_ab && st_ba) chk("R12 a_o", a_o, e_ao);
          else if (st_ba) chk("R10/R3 a_o", a_o, e_ao);
          else chk("R9 a_o", a_o, e_ao);
        end
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step(3);
    rst = 0;
    // R7: live A to B over several words
    en_ab = 1;
    for (int i = 0; i < 6; i++) begin a_i = 8'h11 * i[7:0] ^ 8'hA5; step(1); end
    // R2: capture on rising strobe, hold while strobe stays high
    a_i = 8'h5A; cap_a_clk = 1; step(1);
    a_i = 8'hC3; pick_ab = 1; step(1);
    a_i = 8'h0F; step(3);
    cap_a_clk = 0; step(1);
    // R8: capture in same cycle as stored forwarding
    a_i = 8'h77; cap_a_clk = 1; step(1);
    cap_a_clk = 0; step(2);
    // R11: toggle select
    for (int i = 0; i < 6; i++) begin pick_ab = ~pick_ab; a_i = a_i + 8'h13; step(1); end
    // R9/R3/R10: B to A
    en_ab = 0; en_ba_n = 0; pick_ba = 0;
    for (int i = 0; i < 4; i++) begin b_i = 8'h3C + i[7:0]; step(1); end
    b_i = 8'h96; cap_b_clk = 1; step(1);
    b_i = 8'h21; pick_ba = 1; step(3);
    cap_b_clk = 0; step(1);
    for (int i = 0; i < 4; i++) begin pick_ba = ~pick_ba; b_i = b_i ^ 8'h5F; step(1); end
    // R12: stored exchange both directions
    pick_ab = 1; pick_ba = 1; en_ab = 1; en_ba_n = 0; step(4);
    // R6: both disabled
    en_ab = 0; en_ba_n = 1; step(3);
    // contention: both driving, live selected
    en_ab = 1; en_ba_n = 0; pick_ab = 0; step(2);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      a_i = W'($urandom); b_i = W'($urandom);
      cap_a_clk = $urandom_range(0, 1) == 1; cap_b_clk = $urandom_range(0, 1) == 1;
      pick_ab = $urandom_range(0, 1) == 1; pick_ba = $urandom_range(0, 1) == 1;
      en_ab = $urandom_range(0, 1) == 1; en_ba_n = $urandom_range(0, 1) == 1;
      if (i == 1500) rst = 1;
      if (i == 1502) rst = 0;
      step(1);
    end
    step(2);
    $display("contention cycles flagged and skipped: %0d", contention);
    finish_run();
  end
endmodule